// File: doc/BRIEF.md
# Window Watchdog Frequency Monitor

This block supervises the "still alive" pulse train that a host processor toggles on a dedicated kick line. The kick line is treated as asynchronous. It passes through a synchronizer, and the block then detects its falling edges. The number of clock cycles between consecutive falling edges is measured and sorted into one of three classes: too slow, normal or too fast. The window is set by a single parameter, the timebase unit `UNIT_CYC`. The slow limit is 13 units and the fast limit is 3.82 units rounded to whole cycles, so the two limits always scale together.

A mode input turns the fast check off, which leaves a watchdog that only guards the lower frequency limit. Each classified interval produces a one-cycle status pulse. A level fault flag follows the most recent verdict. The flag also rises without waiting for an edge once the kick line has been quiet for longer than the slow limit, which covers a line stuck high or stuck low. The block only reports faults. Acting on them, for example by pulsing a reset, belongs to the logic around it.

Top module: `wdog_window_mon`

## Requirements
- R1: Only high-to-low transitions of `kick_i` count as kicks. A low-to-high transition produces no status pulse and does not change `fault_o`.
- R2: The interval is the number of clock cycles between two consecutive kicks. Each classified interval raises exactly one of `stat_slow_o`, `stat_ok_o` or `stat_fast_o`, for a single cycle, on the third rising clock edge after the `kick_i` fall is set up.
- R3: An interval longer than SLOW = 13·UNIT_CYC cycles (104 at the default of 8) is classified slow and sets `fault_o` to 1.
- R4: With `lower_only_i` = 0, an interval shorter than FAST = round(3.82·UNIT_CYC) cycles (31 at the default) is classified fast and sets `fault_o` to 1.
- R5: An interval from FAST to SLOW inclusive is classified ok and clears `fault_o` to 0. `fault_o` falls only together with an ok pulse.
- R6: With `lower_only_i` = 1, intervals shorter than FAST are classified ok and the fast class never appears. The slow check still applies.
- R7: If no kick arrives for more than SLOW cycles, `fault_o` rises with no further edge and no status pulse. It rises no earlier than SLOW cycles and no later than SLOW+4 cycles after the last kick, whether the line is held high or held low.
- R8: After reset, `fault_o` = 1 and all status outputs are 0. The first kick after reset only starts a measurement and produces no status. The fault stays set until an ok interval has been measured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| kick_i | input | 1 | Asynchronous kick line from the host; falling edges are kicks |
| lower_only_i | input | 1 | 1 = check only the slow limit, 0 = full window |
| stat_slow_o | output | 1 | One-cycle pulse: last interval too long |
| stat_ok_o | output | 1 | One-cycle pulse: last interval inside the window |
| stat_fast_o | output | 1 | One-cycle pulse: last interval too short |
| fault_o | output | 1 | Level window fault flag |

## Verification
A status pulse and the matching `fault_o` update appear on the third rising clock edge after a falling `kick_i` is driven. Two of those edges are the synchronizer and the third is the classification register. The bench drives `kick_i` on falling clock edges, waits exactly three falling edges before sampling, and samples once more one cycle later to confirm the pulse has ended. The quiet-line timeout lands between SLOW and SLOW+4 cycles after a kick, so the bench samples once below that window and once above it.

// File: rtl/wwm_pkg.sv
package wwm_pkg;

    // Verdict held in the classification register
    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_OK   = 2'd1,
        CLS_SLOW = 2'd2,
        CLS_FAST = 2'd3
    } cls_e;

    // Judge state
    typedef struct packed {
        logic armed;   // a reference kick has been seen since reset
        logic fault;   // level fault flag
        cls_e cls;     // verdict shown for one cycle
    } judge_st_t;

    // Longest acceptable interval: thirteen units
    function automatic int slow_cycles(int unit);
        return 13 * unit;
    endfunction

    // Shortest acceptable interval: 3.82 units, rounded to nearest cycle
    function automatic int fast_cycles(int unit);
        return (382 * unit + 50) / 100;
    endfunction

endpackage

// File: rtl/wwm_sync.sv
module wwm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.chain[STAGES-1];

endmodule

// File: rtl/wwm_fall_det.sv
module wwm_fall_det (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic level_i,
    output logic fall_o
);

    typedef struct packed {
        logic prev;
    } det_st_t;

    det_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.prev = level_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // high last cycle, low now: a kick
    assign fall_o = st_q.prev & ~level_i;

endmodule

// File: rtl/wwm_interval.sv
module wwm_interval #(
    parameter int CNT_W   = 8,
    parameter int SAT_VAL = 105
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             fall_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             timeout_o
);

    localparam logic [CNT_W-1:0] SAT_V = CNT_W'(SAT_VAL);
    localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ivl_st_t;

    ivl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fall_i) begin
            // the kick cycle itself is the first cycle of the new interval
            st_d.cnt = ONE_V;
        end else if (st_q.cnt != SAT_V) begin
            st_d.cnt = st_q.cnt + ONE_V;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o     = st_q.cnt;
    assign timeout_o = (st_q.cnt == SAT_V);

endmodule

// File: rtl/wwm_judge.sv
module wwm_judge
    import wwm_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int SLOW_LIM = 104,
    parameter int FAST_LIM = 31
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             fall_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             timeout_i,
    input  logic             lower_only_i,
    output logic             stat_slow_o,
    output logic             stat_ok_o,
    output logic             stat_fast_o,
    output logic             fault_o
);

    localparam logic [CNT_W-1:0] SLOW_V = CNT_W'(SLOW_LIM);
    localparam logic [CNT_W-1:0] FAST_V = CNT_W'(FAST_LIM);

    judge_st_t st_d, st_q;
    cls_e      verdict;

    always_comb begin
        if (cnt_i > SLOW_V) begin
            verdict = CLS_SLOW;
        end else if (!lower_only_i && (cnt_i < FAST_V)) begin
            verdict = CLS_FAST;
        end else begin
            verdict = CLS_OK;
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.cls = CLS_NONE;
        if (fall_i) begin
            st_d.armed = 1'b1;
            if (st_q.armed) begin
                st_d.cls   = verdict;
                st_d.fault = (verdict != CLS_OK);
            end
        end else if (timeout_i) begin
            st_d.fault = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '{armed: 1'b0, fault: 1'b1, cls: CLS_NONE};
        end else begin
            st_q <= st_d;
        end
    end

    assign stat_slow_o = (st_q.cls == CLS_SLOW);
    assign stat_ok_o   = (st_q.cls == CLS_OK);
    assign stat_fast_o = (st_q.cls == CLS_FAST);
    assign fault_o     = st_q.fault;

endmodule

// File: rtl/wdog_window_mon.sv
module wdog_window_mon
    import wwm_pkg::*;
#(
    parameter int UNIT_CYC    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic kick_i,
    input  logic lower_only_i,
    output logic stat_slow_o,
    output logic stat_ok_o,
    output logic stat_fast_o,
    output logic fault_o
);

    localparam int SLOW_LIM = slow_cycles(UNIT_CYC);
    localparam int FAST_LIM = fast_cycles(UNIT_CYC);
    localparam int SAT_VAL  = SLOW_LIM + 1;
    localparam int CNT_W    = $clog2(SAT_VAL + 1);

    logic             kick_sync;
    logic             kick_fall;
    logic [CNT_W-1:0] ivl_cnt;
    logic             ivl_timeout;

    wwm_sync #(
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (kick_i),
        .sync_o  (kick_sync)
    );

    wwm_fall_det fall_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .level_i (kick_sync),
        .fall_o  (kick_fall)
    );

    wwm_interval #(
        .CNT_W   (CNT_W),
        .SAT_VAL (SAT_VAL)
    ) ivl_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .fall_i    (kick_fall),
        .cnt_o     (ivl_cnt),
        .timeout_o (ivl_timeout)
    );

    wwm_judge #(
        .CNT_W    (CNT_W),
        .SLOW_LIM (SLOW_LIM),
        .FAST_LIM (FAST_LIM)
    ) judge_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .fall_i       (kick_fall),
        .cnt_i        (ivl_cnt),
        .timeout_i    (ivl_timeout),
        .lower_only_i (lower_only_i),
        .stat_slow_o  (stat_slow_o),
        .stat_ok_o    (stat_ok_o),
        .stat_fast_o  (stat_fast_o),
        .fault_o      (fault_o)
    );

endmodule

// File: rtl/wdog_window_mon_chk.sv
module wdog_window_mon_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic lower_only_i,
    input logic stat_slow_o,
    input logic stat_ok_o,
    input logic stat_fast_o,
    input logic fault_o
);

    logic any_stat;
    assign any_stat = stat_slow_o | stat_ok_o | stat_fast_o;

    // R2: at most one class at a time
    assert_one_class_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({stat_slow_o, stat_ok_o, stat_fast_o}));

    // R2: status is a single-cycle pulse
    assert_single_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        any_stat |=> !any_stat);

    // R3: a slow verdict leaves the fault set
    assert_slow_faults_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stat_slow_o |-> fault_o);

    // R4: a fast verdict leaves the fault set
    assert_fast_faults_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stat_fast_o |-> fault_o);

    // R5: fault drops only alongside an ok verdict
    assert_clear_by_ok_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(fault_o) |-> stat_ok_o);

    // R6: no fast verdict when the mode was lower-only at decision time
    assert_no_fast_lower_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stat_fast_o |-> !$past(lower_only_i));

    // R7: a timeout raises the fault silently, without a pulse
    assert_rise_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(fault_o) |-> !stat_ok_o);

endmodule

bind wdog_window_mon wdog_window_mon_chk chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lower_only_i (lower_only_i),
    .stat_slow_o  (stat_slow_o),
    .stat_ok_o    (stat_ok_o),
    .stat_fast_o  (stat_fast_o),
    .fault_o      (fault_o)
);

// File: tb/wdog_window_mon_tb_top.sv
module wdog_window_mon_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int UNIT       = 8;
    localparam int SLOW_B     = 13 * UNIT;   // 104
    localparam int NVEC       = 14;

    // {lower_only, interval, expected class: 0 ok, 1 slow, 2 fast}
    localparam logic [18:0] VECS [NVEC] = '{
        {1'b0, 16'd20,  2'd2},
        {1'b0, 16'd30,  2'd2},
        {1'b0, 16'd31,  2'd0},
        {1'b0, 16'd60,  2'd0},
        {1'b0, 16'd104, 2'd0},
        {1'b0, 16'd105, 2'd1},
        {1'b0, 16'd150, 2'd1},
        {1'b0, 16'd2,   2'd2},
        {1'b1, 16'd20,  2'd0},
        {1'b1, 16'd30,  2'd0},
        {1'b1, 16'd2,   2'd0},
        {1'b1, 16'd104, 2'd0},
        {1'b1, 16'd105, 2'd1},
        {1'b1, 16'd150, 2'd1}
    };

    logic clk = 1'b0;
    logic rst_n;
    logic kick;
    logic lower_only;
    logic stat_slow, stat_ok, stat_fast, fault;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_window_mon #(.UNIT_CYC(UNIT)) dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .kick_i       (kick),
        .lower_only_i (lower_only),
        .stat_slow_o  (stat_slow),
        .stat_ok_o    (stat_ok),
        .stat_fast_o  (stat_fast),
        .fault_o      (fault)
    );

    // compare {slow, ok, fast, fault}
    task automatic chk(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {stat_slow, stat_ok, stat_fast, fault};
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {slow,ok,fast,fault} got %b expected %b", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // rise then fall: a fresh reference kick at the current negedge
    task automatic ref_kick();
        @(negedge clk); kick = 1'b1;
        @(negedge clk); kick = 1'b0;
    endtask

    // next kick exactly n cycles after the last one (n >= 2)
    task automatic kick_after(input int n);
        tick(n - 1); kick = 1'b1;
        tick(1);     kick = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; kick = 1'b0; lower_only = 1'b0;
        tick(4);
        rst_n = 1'b1;
        tick(2);
        chk("R8 reset state", 4'b0001);

        // R8: first kick only arms
        ref_kick();
        tick(3);
        chk("R8 first kick silent", 4'b0001);

        // R5: good interval clears fault
        kick_after(60 - 3);  // already 3 cycles past the arming kick
        tick(3);
        chk("R5 ok clears fault", 4'b0100);
        tick(1);
        chk("R2 pulse ends", 4'b0000);

        // R1: rising edge ignored, line then held high
        kick = 1'b1;          // now 4 cycles after last kick
        tick(3);
        chk("R1 rising edge no status", 4'b0000);
        tick(100 - 7);
        chk("R7 held high, not yet", 4'b0000);
        tick(12);
        chk("R7 held high timeout", 4'b0001);

        // R3: the late kick itself is a slow interval
        kick = 1'b0;
        tick(3);
        chk("R3 late kick slow", 4'b1001);

        // R7: line held low after a good interval
        kick_after(50 - 3);
        tick(3);
        chk("R5 recovery ok", 4'b0100);
        tick(100 - 3);
        chk("R7 held low, not yet", 4'b0000);
        tick(12);
        chk("R7 held low timeout", 4'b0001);

        // table of intervals, both modes (R2 R3 R4 R5 R6)
        for (int i = 0; i < NVEC; i++) begin
            logic [3:0] exp;
            int         n;
            lower_only = VECS[i][18];
            n          = int'(VECS[i][17:2]);
            case (VECS[i][1:0])
                2'd0:    exp = 4'b0100;
                2'd1:    exp = 4'b1001;
                default: exp = 4'b0011;
            endcase
            ref_kick();
            kick_after(n);
            tick(3);
            chk($sformatf("R%0s vector %0d interval %0d",
                          lower_only ? "6" : (VECS[i][1:0] == 2'd2 ? "4" :
                                              (n > SLOW_B ? "3" : "5")), i, n), exp);
            tick(1);
            chk("R2 single cycle pulse", {3'b000, exp[0]});
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule